// File: doc/BRIEF.md
# SDRAM Bank Command Legality Tracker

This block watches the command bus of a synchronous DRAM on behalf of a single bank. On every clock it turns the chip-select, row-strobe, column-strobe and write-enable lines into a command. It then judges that command against the state it holds for the bank. The judged command moves the bank through its steady states (idle, row open, read burst, write burst). It also moves the bank through its timed transient states (opening a row, closing a row, and an access that closes its own row). Two countdowns run out the row-to-column delay and the precharge time. A command that the current state does not allow raises a one-cycle error flag. Such a command leaves the state as it was.

The block is meant to sit beside a memory controller or a bus model as a protocol monitor. There is one instance per bank. A bank-match input tells the instance whether the current command addresses its bank. The row-open delay, the precharge time and the burst length are parameters counted in clock cycles.

Top module: `sdram_bank_tracker`

## Requirements
- R1: The pins {cs_n, ras_n, cas_n, we_n} decode as follows: cs_n=1 is inhibit; 0111 is no-op; 0011 is activate; 0101 is read; 0100 is write; 0110 is burst stop; 0010 is precharge; 0001 is refresh; 0000 is mode-register load.
- R2: Inhibit and no-op are legal in every state. They never raise cmd_err, and they let any running countdown continue.
- R3: In idle (code 0), activate, refresh, mode-register load and precharge are legal. Activate moves the bank to activating (code 1). The other three leave it idle. Read, write and burst stop are errors.
- R4: Activating lasts TRCD cycles from the cycle after the activate, then becomes row active (code 2). Any command other than inhibit or no-op during activating is an error.
- R5: In row active, read and write are legal. With auto_pre=0 they enter read (code 3) or write (code 4). Precharge is also legal. Activate, burst stop, refresh and mode-register load are errors.
- R6: A read or write burst with auto_pre=0 returns to row active after BL cycles. A new read or write inside a burst restarts the BL count in the new direction. Burst stop returns the bank to row active at once. Precharge truncates the burst and enters precharging (code 5).
- R7: Precharging lasts TRP cycles, then becomes idle. Any command other than inhibit or no-op during precharging is an error.
- R8: A read or write issued with auto_pre=1 enters read-with-close (code 6) or write-with-close (code 7). The bank stays there for BL+TRP cycles, then becomes idle. Any command other than inhibit or no-op in these states is an error.
- R9: An illegal command sets cmd_err for exactly the following cycle and leaves bank_state unchanged. If that command lands on the last cycle of a timed state, the move out of that state happens one cycle later.
- R10: A command with bank_hit=0 is treated as a no-op. It raises no error and causes no state change.
- R11: Commands are judged, and the state and countdowns advance, only on a clock where cke is high both on that clock and on the one before. On any other clock everything holds.
- R12: A synchronous reset (rst=1) puts the bank in idle with cmd_err low. The first clock after reset is not judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable seen on the memory bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| auto_pre | input | 1 | Auto-precharge flag sampled with read or write |
| bank_hit | input | 1 | High when the command addresses this bank |
| bank_state | output | 3 | Current bank state code (see R3 to R8) |
| cmd_err | output | 1 | One-cycle pulse after an illegal command |

## Verification
The bench issues illegal commands in the middle of the activating, precharging and auto-close windows. A design that let such a command restart or cancel the countdown would leave those states at the wrong cycle. The bench also restarts a burst inside a burst, and it truncates bursts both by burst stop and by precharge. Here a wrong design would either miss the reload or fall back to row active early. The bench then drops cke in the middle of precharging and raises it again. A design that looked only at the current cke would resume one cycle too soon. A design that kept counting while the clock was gated would reach idle early. Finally, the bench sends an illegal command with bank_hit low, and it sends one back-to-back error pair. This catches a design that judges foreign commands or that stretches or merges the error pulse.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [2:0] {
    C_NOP = 3'd0,
    C_ACT = 3'd1,
    C_RD  = 3'd2,
    C_WR  = 3'd3,
    C_BST = 3'd4,
    C_PRE = 3'd5,
    C_REF = 3'd6,
    C_LMR = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACTV = 3'd1,
    ST_ROW  = 3'd2,
    ST_RD   = 3'd3,
    ST_WR   = 3'd4,
    ST_PRE  = 3'd5,
    ST_RDAP = 3'd6,
    ST_WRAP = 3'd7
  } bank_st_e;

  // Pin pattern to command; chip select high is inhibit, folded into NOP.
  function automatic cmd_e pins_to_cmd(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) begin
      c = C_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = C_NOP;
        3'b011:  c = C_ACT;
        3'b101:  c = C_RD;
        3'b100:  c = C_WR;
        3'b110:  c = C_BST;
        3'b010:  c = C_PRE;
        3'b001:  c = C_REF;
        default: c = C_LMR;
      endcase
    end
    return c;
  endfunction

  // Which commands each state accepts.
  function automatic logic cmd_allowed(input bank_st_e st, input cmd_e c);
    logic ok;
    if (c == C_NOP) begin
      ok = 1'b1;
    end else begin
      case (st)
        ST_IDLE: ok = (c == C_ACT) || (c == C_REF) || (c == C_LMR) || (c == C_PRE);
        ST_ROW:  ok = (c == C_RD) || (c == C_WR) || (c == C_PRE);
        ST_RD,
        ST_WR:   ok = (c == C_RD) || (c == C_WR) || (c == C_PRE) || (c == C_BST);
        default: ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

  function automatic logic is_timed(input bank_st_e st);
    return (st != ST_IDLE) && (st != ST_ROW);
  endfunction

  // Where a timed state goes once its countdown has run out.
  function automatic bank_st_e after_span(input bank_st_e st);
    bank_st_e n;
    case (st)
      ST_ACTV, ST_RD, ST_WR:     n = ST_ROW;
      ST_PRE, ST_RDAP, ST_WRAP:  n = ST_IDLE;
      default:                   n = st;
    endcase
    return n;
  endfunction

  // Number of cycles a state lasts when entered.
  function automatic int span_cycles(input bank_st_e st, input int trcd,
                                     input int trp, input int bl);
    int n;
    case (st)
      ST_ACTV:          n = trcd;
      ST_RD, ST_WR:     n = bl;
      ST_PRE:           n = trp;
      ST_RDAP, ST_WRAP: n = bl + trp;
      default:          n = 1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
  import sbt_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic bank_hit,
  output cmd_e cmd
);

  cmd_e raw_cmd;

  always_comb begin
    raw_cmd = pins_to_cmd(cs_n, ras_n, cas_n, we_n);
    // R10: commands for another bank count as no-ops here
    cmd = bank_hit ? raw_cmd : C_NOP;
  end

endmodule

// File: rtl/sbt_cke_window.sv
module sbt_cke_window (
  input  logic clk,
  input  logic rst,
  input  logic cke,
  output logic chk_en
);

  logic cke_q;

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b0;
    else     cke_q <= cke;
  end

  assign chk_en = cke & cke_q;

  AST_CKE_LOW_BLOCKS_NEXT: assert property (@(posedge clk) disable iff (rst)
    !cke |=> !chk_en) else $error("cke low must gate the next cycle"); // R11

endmodule

// File: rtl/sbt_span_timer.sv
module sbt_span_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_RELOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(load_val)) else $error("reload lost"); // R6
  AST_GATED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt)) else $error("count moved while gated"); // R11
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt == '0) |=> cnt == '0) else $error("count wrapped"); // R7

endmodule

// File: rtl/sbt_bank_fsm.sv
module sbt_bank_fsm
  import sbt_pkg::*;
#(
  parameter int TRCD = 3,
  parameter int TRP  = 3,
  parameter int BL   = 4,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chk_en,
  input  cmd_e          cmd,
  input  logic          auto_pre,
  input  logic          tmr_done,
  output bank_st_e      st,
  output logic          err,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);

  bank_st_e nxt;
  logic     legal;
  logic     err_n;
  logic     start;

  always_comb begin
    legal = cmd_allowed(st, cmd);
    nxt   = st;
    err_n = 1'b0;
    start = 1'b0;
    if (chk_en) begin
      if (!legal) begin
        err_n = 1'b1;
      end else if (cmd == C_NOP) begin
        if (is_timed(st) && tmr_done) nxt = after_span(st);
      end else begin
        case (cmd)
          C_ACT: begin nxt = ST_ACTV; start = 1'b1; end
          C_RD:  begin nxt = auto_pre ? ST_RDAP : ST_RD; start = 1'b1; end
          C_WR:  begin nxt = auto_pre ? ST_WRAP : ST_WR; start = 1'b1; end
          C_BST: nxt = ST_ROW;
          C_PRE: if (st != ST_IDLE) begin nxt = ST_PRE; start = 1'b1; end
          default: ;
        endcase
      end
    end
    tmr_load = start;
    tmr_val  = CW'(span_cycles(nxt, TRCD, TRP, BL) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      err <= 1'b0;
    end else begin
      st  <= nxt;
      err <= err_n;
    end
  end

  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    err |-> st == $past(st)) else $error("illegal command moved state"); // R9
  AST_ERR_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(chk_en)) else $error("error outside cke window"); // R11
  AST_FROZEN_WHEN_GATED: assert property (@(posedge clk) disable iff (rst)
    !chk_en |=> $stable(st)) else $error("state moved while gated"); // R11
  AST_ROW_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ROW && $past(st) != ST_ROW) |->
      ($past(st) == ST_ACTV || $past(st) == ST_RD || $past(st) == ST_WR))
    else $error("bad way into row active"); // R4
  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && $past(st) != ST_IDLE) |->
      ($past(st) == ST_PRE || $past(st) == ST_RDAP || $past(st) == ST_WRAP))
    else $error("bad way into idle"); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (st == ST_IDLE && !err)) else $error("reset not idle"); // R12

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int TRCD = 3,
  parameter int TRP  = 3,
  parameter int BL   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       auto_pre,
  input  logic       bank_hit,
  output logic [2:0] bank_state,
  output logic       cmd_err
);

  localparam int LONGEST = BL + TRP + TRCD;
  localparam int CW      = $clog2(LONGEST + 1);

  cmd_e          cmd_w;
  logic          chk_en_w;
  logic          tmr_done_w;
  logic          tmr_load_w;
  logic [CW-1:0] tmr_val_w;
  bank_st_e      st_w;

  sbt_cmd_decode u_dec (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .bank_hit (bank_hit),
    .cmd      (cmd_w)
  );

  sbt_cke_window u_cke (
    .clk    (clk),
    .rst    (rst),
    .cke    (cke),
    .chk_en (chk_en_w)
  );

  sbt_span_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .run      (chk_en_w),
    .load     (tmr_load_w),
    .load_val (tmr_val_w),
    .done     (tmr_done_w)
  );

  sbt_bank_fsm #(.TRCD(TRCD), .TRP(TRP), .BL(BL), .CW(CW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .chk_en   (chk_en_w),
    .cmd      (cmd_w),
    .auto_pre (auto_pre),
    .tmr_done (tmr_done_w),
    .st       (st_w),
    .err      (cmd_err),
    .tmr_load (tmr_load_w),
    .tmr_val  (tmr_val_w)
  );

  assign bank_state = st_w;

  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
    (chk_en_w && !bank_hit) |=> !cmd_err) else $error("foreign command flagged"); // R10
  AST_NOP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cs_n || {ras_n, cas_n, we_n} == 3'b111) |=> !cmd_err)
    else $error("inhibit or no-op flagged"); // R2

endmodule

// File: tb/tb_sdram_bank_tracker.sv
module tb_sdram_bank_tracker;

  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] P_INH = 4'b1000;
  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_BST = 4'b0110;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam logic [3:0] P_REF = 4'b0001;
  localparam logic [3:0] P_LMR = 4'b0000;

  localparam logic [2:0] S_I = 3'd0, S_AC = 3'd1, S_RA = 3'd2, S_RD = 3'd3,
                         S_WR = 3'd4, S_PC = 3'd5, S_RAP = 3'd6, S_WAP = 3'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic auto_pre = 1'b0, bank_hit = 1'b1;
  logic [2:0] bank_state;
  logic cmd_err;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0] st;
    logic       err;
    string      req;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_bank_tracker #(.TRCD(3), .TRP(3), .BL(4)) dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .auto_pre(auto_pre), .bank_hit(bank_hit),
    .bank_state(bank_state), .cmd_err(cmd_err)
  );

  // Monitor: compares outputs with the queued expectation, away from the edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (bank_state !== e.st || cmd_err !== e.err) begin
          bad++;
          $display("FAIL %s: state=%0d err=%0b expected state=%0d err=%0b",
                   e.req, bank_state, cmd_err, e.st, e.err);
        end
      end
    end
  end

  task automatic push_exp(input logic [2:0] st, input logic err, input string req);
    exp_t e;
    e.st = st; e.err = err; e.req = req;
    q.push_back(e);
  endtask

  // Driver: one command per cycle, expectation for the result after the edge.
  task automatic step(input logic [3:0] pins, input logic ap, input logic hit,
                      input logic ck, input logic [2:0] est, input logic eerr,
                      input string req);
    @(negedge clk);
    rst = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = pins;
    auto_pre = ap; bank_hit = hit; cke = ck;
    @(posedge clk);
    #1 push_exp(est, eerr, req);
  endtask

  task automatic cmd(input logic [3:0] pins, input logic [2:0] est,
                     input logic eerr, input string req);
    step(pins, 1'b0, 1'b1, 1'b1, est, eerr, req);
  endtask

  task automatic nops(input int n, input logic [2:0] est, input string req);
    for (int i = 0; i < n; i++) cmd(P_NOP, est, 1'b0, req);
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1; {cs_n, ras_n, cas_n, we_n} = P_NOP; cke = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 push_exp(S_I, 1'b0, req);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        bad++; total++;
        $display("FAIL watchdog: cycles=%0d expected completion", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    do_reset("R12 reset state");
    cmd(P_NOP, S_I, 1'b0, "R12 first cycle");
    // R3 idle rules, R9 pulse shape
    cmd(P_RD,  S_I, 1'b1, "R3 read in idle");
    cmd(P_NOP, S_I, 1'b0, "R9 pulse one cycle");
    cmd(P_WR,  S_I, 1'b1, "R3 write in idle");
    cmd(P_BST, S_I, 1'b1, "R9 back-to-back error");
    cmd(P_NOP, S_I, 1'b0, "R9 pulse ends");
    cmd(P_REF, S_I, 1'b0, "R3 refresh in idle");
    cmd(P_LMR, S_I, 1'b0, "R1 mode load in idle");
    cmd(P_PRE, S_I, 1'b0, "R3 precharge in idle");
    // R10 foreign bank
    step(P_ACT, 1'b0, 1'b0, 1'b1, S_I, 1'b0, "R10 foreign activate");
    step(P_RD,  1'b0, 1'b0, 1'b1, S_I, 1'b0, "R10 foreign read");
    cmd(P_INH, S_I, 1'b0, "R2 inhibit in idle");
    // R4 activating
    cmd(P_ACT, S_AC, 1'b0, "R3 activate");
    cmd(P_RD,  S_AC, 1'b1, "R4 read while activating");
    cmd(P_NOP, S_AC, 1'b0, "R4 still activating");
    cmd(P_NOP, S_RA, 1'b0, "R4 row active after TRCD");
    // R5 row active
    cmd(P_BST, S_RA, 1'b1, "R5 burst stop in row active");
    cmd(P_ACT, S_RA, 1'b1, "R5 activate in row active");
    cmd(P_REF, S_RA, 1'b1, "R5 refresh in row active");
    cmd(P_INH, S_RA, 1'b0, "R2 inhibit in row active");
    // R6 bursts
    cmd(P_RD, S_RD, 1'b0, "R5 read starts burst");
    nops(3, S_RD, "R6 read burst runs");
    cmd(P_NOP, S_RA, 1'b0, "R6 read burst ends after BL");
    cmd(P_WR, S_WR, 1'b0, "R5 write starts burst");
    cmd(P_NOP, S_WR, 1'b0, "R6 write burst runs");
    cmd(P_RD, S_RD, 1'b0, "R6 read restarts burst");
    nops(3, S_RD, "R6 restarted burst runs");
    cmd(P_NOP, S_RA, 1'b0, "R6 restarted burst ends");
    cmd(P_RD,  S_RD, 1'b0, "R6 read");
    cmd(P_BST, S_RA, 1'b0, "R6 burst stop");
    cmd(P_WR,  S_WR, 1'b0, "R6 write");
    cmd(P_PRE, S_PC, 1'b0, "R6 precharge truncates");
    // R7 precharging
    cmd(P_ACT, S_PC, 1'b1, "R7 activate while precharging");
    cmd(P_NOP, S_PC, 1'b0, "R7 still precharging");
    cmd(P_NOP, S_I,  1'b0, "R7 idle after TRP");
    cmd(P_ACT, S_AC, 1'b0, "R4 activate");
    nops(2, S_AC, "R4 activating");
    cmd(P_NOP, S_RA, 1'b0, "R4 row active");
    // R11 clock enable window
    step(P_RD,  1'b0, 1'b1, 1'b0, S_RA, 1'b0, "R11 cke low ignored");
    step(P_RD,  1'b0, 1'b1, 1'b1, S_RA, 1'b0, "R11 cke previous low ignored");
    step(P_ACT, 1'b0, 1'b1, 1'b1, S_RA, 1'b1, "R11 checking resumes");
    cmd(P_PRE, S_PC, 1'b0, "R5 precharge from row active");
    step(P_NOP, 1'b0, 1'b1, 1'b0, S_PC, 1'b0, "R11 frozen 1");
    step(P_NOP, 1'b0, 1'b1, 1'b0, S_PC, 1'b0, "R11 frozen 2");
    step(P_NOP, 1'b0, 1'b1, 1'b1, S_PC, 1'b0, "R11 frozen 3");
    nops(2, S_PC, "R11 precharge resumes");
    cmd(P_NOP, S_I, 1'b0, "R11 idle after full TRP");
    // R8 auto-close read
    cmd(P_ACT, S_AC, 1'b0, "R4 activate");
    nops(2, S_AC, "R4 activating");
    cmd(P_NOP, S_RA, 1'b0, "R4 row active");
    step(P_RD, 1'b1, 1'b1, 1'b1, S_RAP, 1'b0, "R8 read with close");
    cmd(P_PRE, S_RAP, 1'b1, "R8 precharge during auto-close");
    cmd(P_INH, S_RAP, 1'b0, "R2 inhibit during auto-close");
    nops(4, S_RAP, "R8 auto-close read runs");
    cmd(P_NOP, S_I, 1'b0, "R8 idle after BL+TRP");
    // R8 auto-close write
    cmd(P_ACT, S_AC, 1'b0, "R4 activate");
    nops(2, S_AC, "R4 activating");
    cmd(P_NOP, S_RA, 1'b0, "R4 row active");
    step(P_WR, 1'b1, 1'b1, 1'b1, S_WAP, 1'b0, "R8 write with close");
    cmd(P_WR, S_WAP, 1'b1, "R8 write during auto-close");
    nops(5, S_WAP, "R8 auto-close write runs");
    cmd(P_NOP, S_I, 1'b0, "R8 idle after write close");
    // R12 reset mid-operation
    cmd(P_ACT, S_AC, 1'b0, "R3 activate");
    do_reset("R12 reset while activating");
    cmd(P_NOP, S_I, 1'b0, "R12 idle after reset");
    @(negedge clk);
    @(negedge clk);
    if (q.size() != 0) begin
      bad++;
      total++;
      $display("FAIL R2: queue left=%0d expected 0", q.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule